// File: doc/BRIEF.md
# Bitstream configuration FIFO programmer

This peripheral loads an FPGA configuration image into a downstream configuration port. Software (or an external DMA engine paced by a request line) writes the image as 32-bit words to a single data address. The words land in a small FIFO. While the programmer is enabled, a serializer takes words from the FIFO and sends them to the target one byte per clock, most significant byte first, and counts every byte it sends.

Before enabling, software writes the total image length in bytes. Streaming stops when the current count equals that total. An interrupt rises when the whole image has gone out and the target reports configuration done, or when any error flag sets. The interrupt stays high until software writes zero to the control word. That write also stops the programmer and clears the error flags. The FIFO has no back-pressure. In CPU mode software writes one FIFO-sized block and polls the fill level until it reads zero. In DMA mode the block raises a request whenever at least half the FIFO is free and part of the image is still to be fetched. Each request is expected to deliver half the FIFO capacity in 4-byte beats.

Register offsets (byte addresses): control 0x00, status 0x04, capacity 0x08, fill level 0x0C, total count 0x10, current count 0x14, data port 0x40. All other offsets read zero.

Top module: `cfg_stream_prog`

## Requirements
- R1: After reset these registers read zero: control, status (with the done input low), fill level, total count and current count. The capacity register reads FIFO_DEPTH*4 bytes. `irq`, `dma_req`, `cfg_valid` and `cfg_rst` are low.
- R2: A write to the data port (0x40) pushes one word, and the fill level (0x0C) reads the number of stored words times 4. A data write while the FIFO holds FIFO_DEPTH words is dropped and sets status bit 2 (overflow).
- R3: While enabled (control bit 0), stored words leave on `cfg_byte` with `cfg_valid` high, one byte per cycle, bits 31:24 first. The current count (0x14) rises by one per byte. No new word is taken once the current count equals the total count (0x10).
- R4: Status bit 18 follows the `cfg_done` input. Status bit 1 is a sticky flag set while `cfg_err` is high. Status bit 0 reads the enable state. The error flags occupy status bits 15:1.
- R5: `irq` sets one cycle after either of two conditions: any status bit in 15:1 is set, or the programmer is enabled, the current count equals the total and `cfg_done` is high. It then stays high until a control write of zero.
- R6: A control write of exactly 0x0 disables streaming and clears `irq` and all error flags. Words still in the FIFO stay there.
- R7: Control bit 1 gives a one-cycle pulse on `cfg_rst` in the cycle after the write. The bit reads back as 0. Bits 0 (enable) and 2 (DMA mode) read back as written.
- R8: `dma_req` is high exactly when all of these hold: enable and DMA mode are set, at least FIFO_DEPTH/2 entries are free, and the bytes pushed since enabling are fewer than the total count.
- R9: Writes to status, capacity, fill level and current count have no effect on what those registers read. The total count register reads back the value written.
- R10: A control write that sets enable while the programmer is disabled clears the current count, the fetched-byte count and any partly sent word.
- R11: While disabled, no byte leaves and the FIFO contents and fill level stay unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 8 | Register byte address |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data for `reg_addr` (combinational) |
| dma_req | output | 1 | Request for a half-FIFO burst from the DMA engine |
| irq | output | 1 | Completion or error interrupt, level |
| cfg_byte | output | 8 | Configuration byte to the target |
| cfg_valid | output | 1 | `cfg_byte` is valid this cycle |
| cfg_rst | output | 1 | One-cycle reset pulse to the target |
| cfg_done | input | 1 | Target reports configuration done |
| cfg_err | input | 1 | Target reports a configuration error |

## Verification
A wrong FIFO pointer or count shows at the ports at once: the fill register drifts and the byte stream repeats or skips a word within one word time, four cycles. A counter fault shows as a current count that does not stop at the total, or as a DMA request that stays high after the last word was fetched, in the cycle after the wrong update. A lost or stuck error or interrupt flag shows on `irq` one cycle after its cause, and after the clearing control write.

// File: rtl/cfgp_pkg.sv
package cfgp_pkg;
    localparam int REG_AW = 8;

    localparam logic [REG_AW-1:0] OFS_CTRL  = 8'h00;
    localparam logic [REG_AW-1:0] OFS_STAT  = 8'h04;
    localparam logic [REG_AW-1:0] OFS_CAP   = 8'h08;
    localparam logic [REG_AW-1:0] OFS_FILL  = 8'h0C;
    localparam logic [REG_AW-1:0] OFS_TOTAL = 8'h10;
    localparam logic [REG_AW-1:0] OFS_CUR   = 8'h14;
    localparam logic [REG_AW-1:0] OFS_DATA  = 8'h40;

    // control bits decoded by software
    localparam int CTL_EN  = 0;
    localparam int CTL_RST = 1;
    localparam int CTL_DMA = 2;

    // status layout: bit 0 enable, bits 15:1 errors, bit 18 done
    localparam int ST_DONE  = 18;
    localparam int ERR_W    = 15;
    localparam int ERR_DS   = 0;   // status bit 1
    localparam int ERR_OVF  = 1;   // status bit 2
endpackage

// File: rtl/cfgp_fifo.sv
module cfgp_fifo #(
    parameter int DEPTH = 8,
    parameter int W     = 32
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   push,
    input  logic                   pop,
    input  logic [W-1:0]           din,
    output logic [W-1:0]           head,
    output logic [$clog2(DEPTH):0] count,
    output logic                   full,
    output logic                   empty
);
    localparam int AW = $clog2(DEPTH);

    typedef struct packed {
        logic [AW-1:0] wp;
        logic [AW-1:0] rp;
        logic [AW:0]   cnt;
    } fifo_st_t;

    fifo_st_t st_d, st_q;
    logic [W-1:0] mem_q [DEPTH];

    assign full  = (st_q.cnt == (AW+1)'(DEPTH));
    assign empty = (st_q.cnt == '0);
    assign count = st_q.cnt;
    assign head  = mem_q[st_q.rp];

    always_comb begin
        st_d = st_q;
        if (push) st_d.wp = st_q.wp + 1'b1;
        if (pop)  st_d.rp = st_q.rp + 1'b1;
        case ({push, pop})
            2'b10:   st_d.cnt = st_q.cnt + 1'b1;
            2'b01:   st_d.cnt = st_q.cnt - 1'b1;
            default: st_d.cnt = st_q.cnt;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    always_ff @(posedge clk) begin
        if (push) mem_q[st_q.wp] <= din;
    end

    // R2
    fifo_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.cnt <= (AW+1)'(DEPTH));
    // R2
    no_push_full_chk: assert property (@(posedge clk) disable iff (!rst_n)
        push |-> !full);
    // R3
    no_pop_empty_chk: assert property (@(posedge clk) disable iff (!rst_n)
        pop |-> !empty);
endmodule

// File: rtl/cfgp_serializer.sv
module cfgp_serializer #(
    parameter int CNT_W = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             en,
    input  logic             clear,
    input  logic [CNT_W-1:0] total,
    input  logic             fifo_empty,
    input  logic [31:0]      fifo_head,
    output logic             pop,
    output logic             out_valid,
    output logic [7:0]       out_byte,
    output logic [CNT_W-1:0] cur
);
    typedef struct packed {
        logic [23:0]      sh;
        logic [1:0]       left;
        logic             vld;
        logic [7:0]       byt;
        logic [CNT_W-1:0] cur;
    } ser_st_t;

    ser_st_t st_d, st_q;

    always_comb begin
        st_d     = st_q;
        st_d.vld = 1'b0;
        pop      = 1'b0;
        if (clear) begin
            st_d.cur  = '0;
            st_d.left = '0;
        end else if (en) begin
            if (st_q.left != '0) begin
                st_d.vld  = 1'b1;
                st_d.byt  = st_q.sh[23:16];
                st_d.sh   = {st_q.sh[15:0], 8'h00};
                st_d.left = st_q.left - 1'b1;
                st_d.cur  = st_q.cur + 1'b1;
            end else if (!fifo_empty && st_q.cur != total) begin
                pop       = 1'b1;
                st_d.vld  = 1'b1;
                st_d.byt  = fifo_head[31:24];
                st_d.sh   = fifo_head[23:0];
                st_d.left = 2'd3;
                st_d.cur  = st_q.cur + 1'b1;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign out_valid = st_q.vld;
    assign out_byte  = st_q.byt;
    assign cur       = st_q.cur;

    // R3
    byte_count_chk: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.vld |-> st_q.cur == $past(st_q.cur) + 1'b1);
    // R11
    idle_when_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !en |-> !pop);
endmodule

// File: rtl/cfg_stream_prog.sv
module cfg_stream_prog
    import cfgp_pkg::*;
#(
    parameter int FIFO_DEPTH = 8,
    parameter int CNT_W      = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_wr,
    input  logic [REG_AW-1:0] reg_addr,
    input  logic [31:0]       reg_wdata,
    output logic [31:0]       reg_rdata,
    output logic              dma_req,
    output logic              irq,
    output logic [7:0]        cfg_byte,
    output logic              cfg_valid,
    output logic              cfg_rst,
    input  logic              cfg_done,
    input  logic              cfg_err
);
    localparam int AW        = $clog2(FIFO_DEPTH);
    localparam int CW        = AW + 1;
    localparam int HALF      = FIFO_DEPTH / 2;
    localparam int CAP_BYTES = FIFO_DEPTH * 4;

    typedef struct packed {
        logic             en;
        logic             dma;
        logic             rst_pulse;
        logic [ERR_W-1:0] err;
        logic             irq;
        logic [CNT_W-1:0] total;
        logic [CNT_W-1:0] fetched;
    } top_st_t;

    top_st_t st_d, st_q;

    logic [CW-1:0]    fifo_cnt;
    logic             fifo_full, fifo_empty, pop;
    logic [31:0]      fifo_head;
    logic [CNT_W-1:0] cur;
    logic             wr_ctrl, wr_total, wr_data, push, start, stop, done_hit;

    assign wr_ctrl  = reg_wr && reg_addr == OFS_CTRL;
    assign wr_total = reg_wr && reg_addr == OFS_TOTAL;
    assign wr_data  = reg_wr && reg_addr == OFS_DATA;
    assign push     = wr_data && !fifo_full;
    assign start    = wr_ctrl && reg_wdata[CTL_EN] && !st_q.en;
    assign stop     = wr_ctrl && reg_wdata == 32'h0;
    assign done_hit = st_q.en && cur == st_q.total && cfg_done;

    always_comb begin
        st_d           = st_q;
        st_d.rst_pulse = 1'b0;
        if (wr_ctrl) begin
            st_d.en        = reg_wdata[CTL_EN];
            st_d.dma       = reg_wdata[CTL_DMA];
            st_d.rst_pulse = reg_wdata[CTL_RST];
        end
        if (wr_total) st_d.total = reg_wdata[CNT_W-1:0];
        if (start)
            st_d.fetched = '0;
        else if (push && st_q.en)
            st_d.fetched = st_q.fetched + CNT_W'(4);
        if (wr_data && fifo_full) st_d.err[ERR_OVF] = 1'b1;
        if (cfg_err)              st_d.err[ERR_DS]  = 1'b1;
        if (done_hit || st_q.err != '0) st_d.irq = 1'b1;
        if (stop) begin
            st_d.err = '0;
            st_d.irq = 1'b0;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    always_comb begin
        reg_rdata = 32'h0;
        case (reg_addr)
            OFS_CTRL: begin
                reg_rdata[CTL_EN]  = st_q.en;
                reg_rdata[CTL_DMA] = st_q.dma;
            end
            OFS_STAT: begin
                reg_rdata[0]         = st_q.en;
                reg_rdata[ERR_W:1]   = st_q.err;
                reg_rdata[ST_DONE]   = cfg_done;
            end
            OFS_CAP:   reg_rdata = 32'(CAP_BYTES);
            OFS_FILL:  reg_rdata = 32'(fifo_cnt) << 2;
            OFS_TOTAL: reg_rdata = 32'(st_q.total);
            OFS_CUR:   reg_rdata = 32'(cur);
            default:   reg_rdata = 32'h0;
        endcase
    end

    assign dma_req = st_q.en && st_q.dma && fifo_cnt <= CW'(FIFO_DEPTH - HALF)
                     && st_q.fetched < st_q.total;
    assign irq     = st_q.irq;
    assign cfg_rst = st_q.rst_pulse;

    cfgp_fifo #(.DEPTH(FIFO_DEPTH), .W(32)) u_fifo (
        .clk   (clk),
        .rst_n (rst_n),
        .push  (push),
        .pop   (pop),
        .din   (reg_wdata),
        .head  (fifo_head),
        .count (fifo_cnt),
        .full  (fifo_full),
        .empty (fifo_empty)
    );

    cfgp_serializer #(.CNT_W(CNT_W)) u_ser (
        .clk        (clk),
        .rst_n      (rst_n),
        .en         (st_q.en),
        .clear      (start),
        .total      (st_q.total),
        .fifo_empty (fifo_empty),
        .fifo_head  (fifo_head),
        .pop        (pop),
        .out_valid  (cfg_valid),
        .out_byte   (cfg_byte),
        .cur        (cur)
    );

    // R5
    irq_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        irq && !stop |=> irq);
    // R6
    stop_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
        stop |=> !irq && st_q.err == '0 && !st_q.en);
    // R2
    ovf_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wr_data && fifo_full |=> st_q.err[ERR_OVF]);
    // R8
    dma_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
        dma_req |-> st_q.en && st_q.dma && !fifo_full);
    // R7
    rst_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_rst |-> $past(wr_ctrl && reg_wdata[CTL_RST]));
endmodule

// File: tb/cfg_stream_prog_bench.sv
module cfg_stream_prog_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        reg_wr = 1'b0;
    logic [7:0]  reg_addr = 8'h0;
    logic [31:0] reg_wdata = 32'h0;
    logic [31:0] reg_rdata;
    logic        dma_req, irq, cfg_valid, cfg_rst;
    logic [7:0]  cfg_byte;
    logic        cfg_done = 1'b0;
    logic        cfg_err = 1'b0;

    int total = 0;
    int bad = 0;
    logic [7:0] got[$];

    always #5 clk = ~clk;

    cfg_stream_prog u_cfg_stream_prog (
        .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .dma_req(dma_req),
        .irq(irq), .cfg_byte(cfg_byte), .cfg_valid(cfg_valid),
        .cfg_rst(cfg_rst), .cfg_done(cfg_done), .cfg_err(cfg_err)
    );

    always @(negedge clk) if (cfg_valid) got.push_back(cfg_byte);

    localparam logic [7:0] A_CTRL = 8'h00, A_STAT = 8'h04, A_CAP = 8'h08,
        A_FILL = 8'h0C, A_TOT = 8'h10, A_CUR = 8'h14, A_DATA = 8'h40;

    // {address, write value, expected readback}
    localparam logic [71:0] TBL [6] = '{
        {8'h04, 32'hFFFF_FFFF, 32'h0000_0000},
        {8'h08, 32'h0000_0000, 32'h0000_0020},
        {8'h0C, 32'h0000_1234, 32'h0000_0000},
        {8'h14, 32'h0000_00AB, 32'h0000_0000},
        {8'h10, 32'h0000_0024, 32'h0000_0024},
        {8'h10, 32'h0000_0000, 32'h0000_0000}
    };

    function automatic logic [31:0] word(input int i);
        return 32'hA0B1_C2D3 ^ (32'(i) * 32'h0103_0507);
    endfunction

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [7:0] a, input logic [31:0] d);
        reg_addr = a; reg_wdata = d; reg_wr = 1'b1;
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    task automatic rd(input logic [7:0] a, output logic [31:0] d);
        reg_addr = a;
        #1;
        d = reg_rdata;
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    // compare the captured stream with words first..first+n-1, MSB first
    task automatic check_stream(input string tag, input int first, input int n);
        int mism = 0;
        total++;
        if (got.size() != n * 4) mism = 1;
        else
            for (int i = 0; i < n * 4; i++)
                if (got[i] !== word(first + i / 4)[31 - 8 * (i % 4) -: 8]) mism++;
        if (mism != 0) begin
            bad++;
            $display("FAIL %s actual=%0d bytes expected=%0d bytes, %0d mismatches",
                     tag, got.size(), n * 4, mism);
        end
    endtask

    initial begin
        #2000000;
        bad++;
        $display("FAIL watchdog actual=running expected=finished");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        logic [31:0] v;
        idle(3);
        rst_n = 1'b1;
        idle(1);

        // R1 reset state
        rd(A_CTRL, v); check("R1 ctrl", v, 0);
        rd(A_STAT, v); check("R1 status", v, 0);
        rd(A_CAP, v);  check("R1 capacity", v, 32);
        rd(A_FILL, v); check("R1 fill", v, 0);
        rd(A_TOT, v);  check("R1 total", v, 0);
        rd(A_CUR, v);  check("R1 current", v, 0);
        check("R1 outputs", {irq, dma_req, cfg_valid, cfg_rst}, 0);

        // R9 write/readback table
        for (int i = 0; i < 6; i++) begin
            wr(TBL[i][71:64], TBL[i][63:32]);
            rd(TBL[i][71:64], v);
            check($sformatf("R9 row %0d", i), v, TBL[i][31:0]);
        end

        // R7 reset pulse and control readback
        wr(A_CTRL, 32'h3);
        check("R7 pulse high", cfg_rst, 1);
        rd(A_CTRL, v); check("R7 ctrl readback", v, 32'h1);
        idle(1);
        check("R7 pulse one cycle", cfg_rst, 0);
        wr(A_CTRL, 32'h0);

        // R2 / R11 fill while disabled
        for (int i = 0; i < 3; i++) wr(A_DATA, word(i));
        rd(A_FILL, v); check("R2 fill 3 words", v, 12);
        got.delete();
        idle(10);
        check("R11 no output when disabled", got.size(), 0);
        rd(A_FILL, v); check("R11 fill kept", v, 12);

        // R3 stream, R4 done status, R5 completion irq, R6 clear
        wr(A_TOT, 12);
        wr(A_CTRL, 32'h1);
        idle(20);
        check_stream("R3 stream 3 words", 0, 3);
        rd(A_CUR, v);  check("R3 current count", v, 12);
        rd(A_FILL, v); check("R3 fill drained", v, 0);
        check("R5 no irq before done", irq, 0);
        cfg_done = 1'b1;
        rd(A_STAT, v); check("R4 done and enable status", v, 32'h0004_0001);
        idle(1);
        check("R5 irq on completion", irq, 1);
        idle(3);
        check("R5 irq held", irq, 1);
        wr(A_CTRL, 32'h0);
        check("R6 irq cleared", irq, 0);
        cfg_done = 1'b0;

        // R3 stop at total, R6 contents kept, R10 restart
        for (int i = 3; i < 6; i++) wr(A_DATA, word(i));
        wr(A_TOT, 8);
        got.delete();
        wr(A_CTRL, 32'h1);
        idle(20);
        check_stream("R3 stops at total", 3, 2);
        rd(A_FILL, v); check("R3 word left in fifo", v, 4);
        wr(A_CTRL, 32'h0);
        idle(6);
        rd(A_FILL, v); check("R6 fifo kept after stop", v, 4);
        rd(A_CUR, v);  check("R6 current kept after stop", v, 8);
        wr(A_TOT, 4);
        got.delete();
        wr(A_CTRL, 32'h1);
        rd(A_CUR, v);  check("R10 current cleared on enable", v, 0);
        idle(10);
        check_stream("R10 remaining word", 5, 1);
        wr(A_CTRL, 32'h0);

        // R2 overflow drop
        for (int i = 10; i < 19; i++) wr(A_DATA, word(i));
        rd(A_FILL, v); check("R2 fill full", v, 32);
        rd(A_STAT, v); check("R2 overflow flag bit 2", v, 32'h4);
        idle(1);
        check("R5 irq on error", irq, 1);
        wr(A_CTRL, 32'h0);
        rd(A_STAT, v); check("R6 errors cleared", v, 0);
        check("R6 irq cleared after error", irq, 0);
        wr(A_TOT, 32);
        got.delete();
        wr(A_CTRL, 32'h1);
        idle(40);
        check_stream("R2 dropped word absent", 10, 8);
        wr(A_CTRL, 32'h0);

        // R4 downstream error flag
        cfg_err = 1'b1;
        idle(1);
        cfg_err = 1'b0;
        rd(A_STAT, v); check("R4 downstream error bit 1", v, 32'h2);
        idle(1);
        check("R5 irq on downstream error", irq, 1);
        wr(A_CTRL, 32'h0);
        check("R6 irq cleared after ds error", irq, 0);

        // R8 DMA request
        wr(A_CTRL, 32'h4);
        check("R8 no request without enable", dma_req, 0);
        rd(A_CTRL, v); check("R7 dma bit readback", v, 32'h4);
        for (int i = 20; i < 25; i++) wr(A_DATA, word(i));
        wr(A_TOT, 16);
        wr(A_CTRL, 32'h5);
        check("R8 no request with free below half", dma_req, 0);
        idle(30);
        rd(A_CUR, v); check("R3 DMA mode stream count", v, 16);
        check("R8 request with room and bytes left", dma_req, 1);
        for (int i = 25; i < 29; i++) wr(A_DATA, word(i));
        check("R8 request drops when all fetched", dma_req, 0);
        wr(A_CTRL, 32'h0);
        wr(A_TOT, 20);
        wr(A_CTRL, 32'h1);
        idle(30);
        rd(A_FILL, v); check("R3 final drain", v, 0);
        wr(A_CTRL, 32'h0);

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule